// File: doc/BRIEF.md
# Fault-Injectable Three-Input NAND with Graded Input Delays

This cell stands in for one three-input NAND gate in a clocked model of a combinational netlist. Each clock cycle stands for one fixed slice of circuit time. Every input pin first passes through its own voltage-ramp counter. The counter climbs toward full scale while the pin is high and falls toward zero while it is low. The step size shrinks as the level nears its end point, and the pin's logic value is the counter's top bit, so it changes at the half-scale point. The steepness of the rising ramp and of the falling ramp is set separately for each pin. A pulse that reverses before its ramp has crossed half scale never reaches the gate, and a pulse that reverses just after crossing comes out shortened. The gate function is applied to the three counter top bits.

For fault injection, each cell holds one mask flip-flop. The mask flip-flops of all cells are linked into a serial chain through the scan-in and scan-out ports, and the target is chosen by shifting a pattern in. A shared inject line is then raised. Only the cell whose mask is set inverts its output, and it does so for as long as inject stays high.

Top module: `vtq_nand3_cell`

## Requirements
- R1: While reset is held and right after it is released, q_out is 1 and scan_out is 0, because all ramp levels and the mask start at zero.
- R2: While a pin is high and its level L is below full scale F = 2^VRES-1, L rises each clock by ((F-L) >> rise_shift)+1, clipped at F. Pin p's rise_shift is RISE_SHIFTS[4p+3:4p].
- R3: While a pin is low and L is above 0, L falls each clock by (L >> fall_shift)+1, clipped at 0. Pin p's fall_shift is FALL_SHIFTS[4p+3:4p].
- R4: Each pin's delayed bit is bit VRES-1 of its level. With the mask clear, q_out is the NAND of the three delayed bits.
- R5: A pin change that reverses before its level crosses bit VRES-1 never shows at q_out.
- R6: Different per-pin shifts give different propagation delays. The number of cycles from a pin change to the q_out change equals the number of ramp steps needed to cross half scale.
- R7: The mask loads scan_in on every clock while scan_en is 1 and holds while scan_en is 0. scan_out always shows the mask.
- R8: While the mask is 1 and inject is 1, q_out is the inverse of the NAND of the delayed bits, whichever value that NAND has.
- R9: While the mask is 0, inject has no effect on q_out.
- R10: A level held at full scale, or at zero, by a steady input stays there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Emulation clock, one time slice per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_a | input | 1 | Logic input, pin 0 |
| in_b | input | 1 | Logic input, pin 1 |
| in_c | input | 1 | Logic input, pin 2 |
| q_out | output | 1 | Gate output, including any injected pulse |
| scan_en | input | 1 | Shift enable for the mask chain |
| scan_in | input | 1 | Serial mask data from the previous cell |
| scan_out | output | 1 | Mask value, fed to the next cell |
| inject | input | 1 | Shared transient-injection strobe |

## Verification
The hardest situation to reach is a level that turns back partway up its ramp, as happens with an input pulse shorter than the gate delay. The stimulus first holds all pins high until every level saturates. It then drops one pin for a single cycle and checks that q_out never moves. It also raises one pin for a single cycle from zero while the other two are high. The exact crossing cycle for each pin is computed in the bench from the shift parameters, and it is checked both one cycle before the q_out change and at the change itself.

// File: rtl/vtq_pkg.sv
package vtq_pkg;
  localparam int unsigned VTQ_PINS = 3;
  localparam int unsigned SHIFT_W  = 4;

  typedef enum logic [1:0] {
    GK_NAND = 2'd0,
    GK_NOR  = 2'd1,
    GK_AND  = 2'd2,
    GK_OR   = 2'd3
  } gate_kind_e;
endpackage

// File: rtl/vtq_ramp_counter.sv
module vtq_ramp_counter #(
  parameter int unsigned VRES     = 5,
  parameter int unsigned RISE_SH  = 2,
  parameter int unsigned FALL_SH  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dly_bit
);
  localparam int unsigned W = VRES + 1;
  localparam logic [VRES-1:0] FULL = {VRES{1'b1}};

  logic [VRES-1:0] lvl_q, lvl_d;
  logic [W-1:0]    room, step;
  logic            lvl_en;

  always_comb begin
    lvl_d = lvl_q;
    if (din) begin
      room = W'(FULL) - W'(lvl_q);
      step = (room >> RISE_SH) + W'(1);
      if (step >= room) lvl_d = FULL;
      else              lvl_d = VRES'(W'(lvl_q) + step);
    end else begin
      room = W'(lvl_q);
      step = (room >> FALL_SH) + W'(1);
      if (step >= room) lvl_d = '0;
      else              lvl_d = VRES'(W'(lvl_q) - step);
    end
  end

  assign lvl_en = din ? (lvl_q != FULL) : (lvl_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= '0;
    else if (lvl_en) lvl_q <= lvl_d;
  end

  assign dly_bit = lvl_q[VRES-1];

  p_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (din && lvl_q != FULL) |=> (lvl_q > $past(lvl_q)));
  p_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!din && lvl_q != '0) |=> (lvl_q < $past(lvl_q)));
  p_top_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (din && lvl_q == FULL) |=> (lvl_q == FULL));
  p_bot_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!din && lvl_q == '0) |=> (lvl_q == '0));
endmodule

// File: rtl/vtq_gate_fn.sv
module vtq_gate_fn
  import vtq_pkg::*;
#(
  parameter gate_kind_e GATE = GK_NAND,
  parameter int unsigned NPIN = VTQ_PINS
) (
  input  logic [NPIN-1:0] bits,
  output logic            fn_out
);
  generate
    if (GATE == GK_NAND) begin : g_nand
      assign fn_out = ~&bits;
    end else if (GATE == GK_NOR) begin : g_nor
      assign fn_out = ~|bits;
    end else if (GATE == GK_AND) begin : g_and
      assign fn_out = &bits;
    end else begin : g_or
      assign fn_out = |bits;
    end
  endgenerate
endmodule

// File: rtl/vtq_mask_stage.sv
module vtq_mask_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic scan_en,
  input  logic scan_in,
  output logic mask_q
);
  logic mask_d;

  always_comb mask_d = scan_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= 1'b0;
    else if (scan_en) mask_q <= mask_d;
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> $stable(mask_q));
  p_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> (mask_q == $past(scan_in)));
endmodule

// File: rtl/vtq_nand3_cell.sv
module vtq_nand3_cell
  import vtq_pkg::*;
#(
  parameter int unsigned VRES = 5,
  parameter logic [VTQ_PINS*SHIFT_W-1:0] RISE_SHIFTS = 12'h122,
  parameter logic [VTQ_PINS*SHIFT_W-1:0] FALL_SHIFTS = 12'h132,
  parameter gate_kind_e GATE = GK_NAND
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_a,
  input  logic in_b,
  input  logic in_c,
  output logic q_out,
  input  logic scan_en,
  input  logic scan_in,
  output logic scan_out,
  input  logic inject
);
  logic [VTQ_PINS-1:0] pin_raw, pin_dly;
  logic fn_out, mask_q, hit;

  assign pin_raw = {in_c, in_b, in_a};

  for (genvar g = 0; g < VTQ_PINS; g++) begin : g_pin
    vtq_ramp_counter #(
      .VRES    (VRES),
      .RISE_SH (int'(RISE_SHIFTS[g*SHIFT_W +: SHIFT_W])),
      .FALL_SH (int'(FALL_SHIFTS[g*SHIFT_W +: SHIFT_W]))
    ) u_ramp (
      .clk     (clk),
      .rst_n   (rst_n),
      .din     (pin_raw[g]),
      .dly_bit (pin_dly[g])
    );
  end

  vtq_gate_fn #(.GATE(GATE), .NPIN(VTQ_PINS)) u_fn (
    .bits   (pin_dly),
    .fn_out (fn_out)
  );

  vtq_mask_stage u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .scan_en (scan_en),
    .scan_in (scan_in),
    .mask_q  (mask_q)
  );

  assign hit      = mask_q & inject;
  assign q_out    = fn_out ^ hit;
  assign scan_out = mask_q;

  p_inject_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_out && inject) |-> (q_out != fn_out));
  p_inject_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_out |-> (q_out == fn_out));
  p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (q_out && !scan_out));
endmodule

// File: tb/vtq_nand3_cell_tb.sv
`timescale 1ns/1ps
module vtq_nand3_cell_tb_top;
  localparam int VRES = 5;
  localparam int FULL = (1 << VRES) - 1;
  localparam logic [11:0] RSH = 12'h122;
  localparam logic [11:0] FSH = 12'h132;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_a = 0, in_b = 0, in_c = 0, scan_en = 0, scan_in = 0, inject = 0;
  logic q_out, scan_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vtq_nand3_cell #(.VRES(VRES), .RISE_SHIFTS(RSH), .FALL_SHIFTS(FSH)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .q_out(q_out), .scan_en(scan_en), .scan_in(scan_in),
    .scan_out(scan_out), .inject(inject));

  // bench model of the ramps, built from R2/R3
  int m_lvl [3];
  bit m_mask;

  function automatic int rs(int p); return int'(RSH[4*p +: 4]); endfunction
  function automatic int fs(int p); return int'(FSH[4*p +: 4]); endfunction
  function automatic int up(int l, int sh);
    int s = ((FULL - l) >> sh) + 1;
    return (l + s > FULL) ? FULL : l + s;
  endfunction
  function automatic int dn(int l, int sh);
    int s = (l >> sh) + 1;
    return (s > l) ? 0 : l - s;
  endfunction
  function automatic int cross_dn(int sh);
    int l = FULL; int n = 0;
    while (l >= (FULL + 1) / 2) begin l = dn(l, sh); n++; end
    return n;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < 3; p++) m_lvl[p] = 0;
      m_mask = 0;
    end else begin
      logic [2:0] ins;
      ins = {in_c, in_b, in_a};
      for (int p = 0; p < 3; p++)
        m_lvl[p] = ins[p] ? up(m_lvl[p], rs(p)) : dn(m_lvl[p], fs(p));
      if (scan_en) m_mask = scan_in;
    end
  end

  function automatic bit exp_q();
    bit f;
    f = !((m_lvl[0] >= 16) && (m_lvl[1] >= 16) && (m_lvl[2] >= 16));
    return f ^ (m_mask & inject);
  endfunction

  task automatic chk(string req, logic got, logic expv);
    checks++;
    if (got !== expv) begin
      errors++;
      $display("FAIL %s got %0b expected %0b at %0t", req, got, expv, $time);
    end
  endtask

  task automatic run_model(string req, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, q_out, exp_q());
    end
  endtask

  task automatic t_reset();
    #1; chk("R1 q in reset", q_out, 1'b1);
    chk("R1 scan_out in reset", scan_out, 1'b0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1 q after release", q_out, 1'b1);
    chk("R1 scan_out after release", scan_out, 1'b0);
  endtask

  task automatic t_rise();
    {in_c, in_b, in_a} = 3'b111;
    run_model("R2 R4 rising ramp", 12);
    chk("R4 all high settles", q_out, 1'b0);
    run_model("R10 hold at full", 6);
    chk("R10 still low", q_out, 1'b0);
  endtask

  task automatic t_per_pin();
    int n0, n2;
    n0 = cross_dn(fs(0)); n2 = cross_dn(fs(2));
    chk("R6 pins differ", n0 != n2, 1'b1);
    in_a = 0;
    for (int i = 1; i <= n0; i++) begin
      @(negedge clk);
      chk("R6 R3 pin0 fall timing", q_out, (i == n0));
    end
    in_a = 1; run_model("R2 pin0 back up", 10);
    in_c = 0;
    for (int i = 1; i <= n2; i++) begin
      @(negedge clk);
      chk("R6 R3 pin2 fall timing", q_out, (i == n2));
    end
    in_c = 1; run_model("R2 pin2 back up", 10);
    chk("R4 settled low", q_out, 1'b0);
  endtask

  task automatic t_filter();
    in_b = 0; @(negedge clk); in_b = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); chk("R5 short low pulse filtered", q_out, 1'b0);
    end
    in_a = 0; run_model("R3 pin0 down", 12);
    chk("R10 low held", q_out, 1'b1);
    in_a = 1; @(negedge clk); in_a = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); chk("R5 short high pulse filtered", q_out, 1'b1);
    end
    in_a = 1; run_model("R2 restore", 12);
  endtask

  task automatic t_scan();
    scan_en = 1; scan_in = 1; @(negedge clk);
    chk("R7 shift one", scan_out, 1'b1);
    scan_in = 0; @(negedge clk);
    chk("R7 shift zero", scan_out, 1'b0);
    scan_in = 1; @(negedge clk);
    scan_en = 0;
    for (int i = 0; i < 4; i++) begin
      scan_in = i[0]; @(negedge clk);
      chk("R7 hold", scan_out, 1'b1);
    end
  endtask

  task automatic t_inject();
    inject = 1; #0.5;
    chk("R8 flip low output", q_out, 1'b1);
    run_model("R8 inject held", 3);
    inject = 0; #0.5;
    chk("R8 release", q_out, 1'b0);
    in_a = 0; run_model("R3 drop pin0", 12);
    inject = 1; #0.5;
    chk("R8 flip high output", q_out, 1'b0);
    inject = 0; #0.5;
    chk("R8 release high", q_out, 1'b1);
    in_a = 1; run_model("R2 raise pin0", 12);
  endtask

  task automatic t_nomask();
    scan_en = 1; scan_in = 0; @(negedge clk); scan_en = 0;
    chk("R9 mask cleared", scan_out, 1'b0);
    inject = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); chk("R9 inject ignored", q_out, 1'b0);
    end
    inject = 0;
  endtask

  initial begin
    t_reset();
    t_rise();
    t_per_pin();
    t_filter();
    t_scan();
    t_inject();
    t_nomask();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule